// File: doc/BRIEF.md
# LCD Panel Controller Register and Interrupt Unit

This block is the software-visible face of a small LCD panel controller. A 32-bit register port with byte offsets reaches six word registers: control, three timing words, a read-only status word and a subpanel word. The stored values are decoded into plain configuration outputs (pixel load mode, TFT and mono flags, width and height minus one, subpanel word) for the fetch and timing logic beside it.

The unit also owns three sticky status flags and one level interrupt. The flags are frame-done, palette-done and sync-error. Writing the enable bit of the control register runs a short sequence that clears or sets these flags. Two event inputs from the fetch engine set palette-done and sync-error, and a sync-error event also drops the enable. The interrupt is a function of flags and mask bits that are all held in flops.

Top module: `pnl_csr`

## Requirements
- R1: After reset every stored field and flag is zero and the interrupt is low. Reads then return 0xfe000c34 at 0x00, 0x0000000f at 0x04, 0 at 0x08, 0xfc000000 at 0x0c, 0 at 0x10 and 0 at 0x14.
- R2: A write to 0x00 captures several fields. Enable comes from bit 0, mono from bit 1, the 2-bit interrupt mask from bits 4:3, TFT from bit 7 and the load mode from bits 21:20. The value ANDed with 0x01cff300 is kept as well. A read of 0x00 returns that kept value ORed with 0xfe000c34, TFT at bits 23 and 7, the load mode at 21:20, the mask at 4:3, mono at 1 and enable at 0.
- R3: Writes to 0x04 and 0x08 store the whole word. Bits 9:0 drive the width-minus-one and height-minus-one outputs. A read returns the word, and at 0x04 it is ORed with 0x0000000f.
- R4: A write to 0x0c stores the whole word, and a read returns it ORed with 0xfc000000.
- R5: Offset 0x10 reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0. Writes to it change nothing.
- R6: A write to 0x14 stores the value ANDed with 0xa1ffffff, and the same value appears on the subpanel output.
- R7: Any other offset reads as zero, and a write to it changes no register.
- R8: The interrupt is high whenever frame-done and mask bit 0 are both set, or palette-done and mask bit 1 are both set, or sync-error is set, with no mask on sync-error.
- R9: A control write that changes enable from 1 to 0 clears sync-error. It also sets frame-done unless the load mode written in that same write equals 1. The block then becomes idle.
- R10: A control write that changes enable from 0 to 1 clears frame-done and palette-done only when the block is idle. Reset and write-driven disables make it idle. A disable caused by a sync-error event does not.
- R11: A palette event sets palette-done. A sync event sets sync-error and clears enable without setting frame-done.
- R12: When an event falls in the same cycle as an enable or disable write, the event is applied after the write's sequence and wins on any flag or enable bit both touch.
- R13: Read data is registered. It changes on the clock edge that follows a read strobe and holds its value in every cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pal_evt | input | 1 | Palette-loaded event from the fetch engine |
| sync_evt | input | 1 | Sync-error event from the fetch engine |
| irq | output | 1 | Level interrupt |
| cfg_enable | output | 1 | Controller enable |
| cfg_load_mode | output | 2 | Palette/pixel load mode |
| cfg_tft | output | 1 | TFT panel select |
| cfg_mono | output | 1 | Monochrome select |
| cfg_width_m1 | output | DIM_W | Panel width minus one |
| cfg_height_m1 | output | DIM_W | Panel height minus one |
| cfg_subpanel | output | 32 | Stored subpanel word |

## Verification
An enable or disable written by software can meet a fetch-engine event in the same clock edge, and then both the flag sequencer and the event path want the same flags. The bench provokes this by raising a sync event in the same cycle as a disabling control write, and a palette event in the same cycle as an enabling write from idle. It judges the outcome by the status word and the interrupt level. After the first case, frame-done and sync-error are both set with enable low. After the second, frame-done is cleared while palette-done and the earlier sync-error remain set.

// File: rtl/pnl_csr_pkg.sv
package pnl_csr_pkg;

  localparam int DATA_W = 32;
  localparam int NREG   = 6;

  // register index; byte offset is index * 4
  typedef enum logic [2:0] {
    IX_CTRL = 3'd0,
    IX_TIM0 = 3'd1,
    IX_TIM1 = 3'd2,
    IX_TIM2 = 3'd3,
    IX_STAT = 3'd4,
    IX_SUBP = 3'd5
  } reg_ix_e;

  // control field positions
  localparam int CB_EN      = 0;
  localparam int CB_MONO    = 1;
  localparam int CB_MASK    = 3;
  localparam int CB_TFT     = 7;
  localparam int CB_MODE    = 20;
  localparam int CB_TFT_HI  = 23;

  // status field positions
  localparam int SB_FRAME   = 0;
  localparam int SB_SYNC    = 2;
  localparam int SB_PAL     = 6;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h01cf_f300;
  localparam logic [DATA_W-1:0] CTRL_ONES = 32'hfe00_0c34;
  localparam logic [DATA_W-1:0] TIM0_ONES = 32'h0000_000f;
  localparam logic [DATA_W-1:0] TIM2_ONES = 32'hfc00_0000;
  localparam logic [DATA_W-1:0] SUBP_KEEP = 32'ha1ff_ffff;

  // load mode in which a disable does not raise frame-done
  localparam logic [1:0] MODE_NO_FRAME = 2'd1;

  typedef struct packed {
    logic       frame;
    logic       pal;
    logic       sync;
  } flag_vec_t;

endpackage

// File: rtl/pnl_csr_decode.sv
module pnl_csr_decode
  import pnl_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);

  localparam int STRIDE = 4;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = (addr == ADDR_W'(g * STRIDE));
  end

endmodule

// File: rtl/pnl_csr_flags.sv
module pnl_csr_flags
  import pnl_csr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ctl_wr,
  input  logic      wr_en,
  input  logic [1:0] wr_mode,
  input  logic [1:0] mask,
  input  logic      pal_evt,
  input  logic      sync_evt,
  output logic      en,
  output flag_vec_t flags,
  output logic      irq
);

  logic      en_q, en_n;
  logic      idle_q, idle_n;
  flag_vec_t fl_q, fl_n;

  always_comb begin
    en_n   = en_q;
    idle_n = idle_q;
    fl_n   = fl_q;
    if (ctl_wr && (wr_en != en_q)) begin
      en_n = wr_en;
      if (!wr_en) begin
        fl_n.sync = 1'b0;
        idle_n    = 1'b1;
        if (wr_mode != MODE_NO_FRAME) fl_n.frame = 1'b1;
      end else if (idle_q) begin
        fl_n.frame = 1'b0;
        fl_n.pal   = 1'b0;
        idle_n     = 1'b0;
      end
    end
    // events from the fetch engine take effect after the sequence
    if (pal_evt) fl_n.pal = 1'b1;
    if (sync_evt) begin
      fl_n.sync = 1'b1;
      en_n      = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      idle_q <= 1'b1;
      fl_q   <= '0;
    end else begin
      en_q   <= en_n;
      idle_q <= idle_n;
      fl_q   <= fl_n;
    end
  end

  assign en    = en_q;
  assign flags = fl_q;
  assign irq   = (fl_q.frame & mask[0]) | (fl_q.pal & mask[1]) | fl_q.sync;

  a_r9_disable_clears_sync: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wr_en && en_q && !sync_evt) |=> !fl_q.sync);

  a_r9_disable_sets_frame: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wr_en && en_q && wr_mode != MODE_NO_FRAME) |=> fl_q.frame);

  a_r10_idle_enable_clears: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_en && !en_q && idle_q && !pal_evt) |=> (!fl_q.frame && !fl_q.pal));

  a_r11_sync_event: assert property (@(posedge clk) disable iff (rst)
    sync_evt |=> (fl_q.sync && !en_q));

  a_r11_pal_event: assert property (@(posedge clk) disable iff (rst)
    pal_evt |=> fl_q.pal);

  a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && !pal_evt && !sync_evt) |=> ($stable(fl_q) && $stable(en_q)));

endmodule

// File: rtl/pnl_csr_bank.sv
module pnl_csr_bank
  import pnl_csr_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [NREG-1:0]   hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              en,
  input  flag_vec_t         flags,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        mode,
  output logic [1:0]        mask,
  output logic              tft,
  output logic              mono,
  output logic [DIM_W-1:0]  width_m1,
  output logic [DIM_W-1:0]  height_m1,
  output logic [DATA_W-1:0] subpanel
);

  localparam int NTIM = 3;

  logic [1:0]        mode_q, mask_q;
  logic              tft_q, mono_q;
  logic [DATA_W-1:0] keep_q;
  logic [DATA_W-1:0] tim_q [NTIM];
  logic [DATA_W-1:0] subp_q;
  logic [DATA_W-1:0] word [NREG];
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      mask_q <= '0;
      tft_q  <= 1'b0;
      mono_q <= 1'b0;
      keep_q <= '0;
    end else if (wr && hit[IX_CTRL]) begin
      mode_q <= wdata[CB_MODE +: 2];
      mask_q <= wdata[CB_MASK +: 2];
      tft_q  <= wdata[CB_TFT];
      mono_q <= wdata[CB_MONO];
      keep_q <= wdata & CTRL_KEEP;
    end
  end

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    always_ff @(posedge clk) begin
      if (rst)                               tim_q[g] <= '0;
      else if (wr && hit[int'(IX_TIM0) + g]) tim_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     subp_q <= '0;
    else if (wr && hit[IX_SUBP]) subp_q <= wdata & SUBP_KEEP;
  end

  always_comb begin
    word[IX_CTRL] = CTRL_ONES | keep_q
                  | (DATA_W'(tft_q)  << CB_TFT_HI)
                  | (DATA_W'(mode_q) << CB_MODE)
                  | (DATA_W'(tft_q)  << CB_TFT)
                  | (DATA_W'(mask_q) << CB_MASK)
                  | (DATA_W'(mono_q) << CB_MONO)
                  | (DATA_W'(en)     << CB_EN);
    word[IX_TIM0] = tim_q[0] | TIM0_ONES;
    word[IX_TIM1] = tim_q[1];
    word[IX_TIM2] = tim_q[2] | TIM2_ONES;
    word[IX_STAT] = (DATA_W'(flags.pal)   << SB_PAL)
                  | (DATA_W'(flags.sync)  << SB_SYNC)
                  | (DATA_W'(flags.frame) << SB_FRAME);
    word[IX_SUBP] = subp_q;
    rd_word = '0;
    for (int i = 0; i < NREG; i++) begin
      rd_word = rd_word | ({DATA_W{hit[i]}} & word[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_word;
  end

  assign rdata     = rdata_q;
  assign mode      = mode_q;
  assign mask      = mask_q;
  assign tft       = tft_q;
  assign mono      = mono_q;
  assign width_m1  = tim_q[0][DIM_W-1:0];
  assign height_m1 = tim_q[1][DIM_W-1:0];
  assign subpanel  = subp_q;

  a_r2_ctrl_ones: assert property (@(posedge clk) disable iff (rst)
    (rd && hit[IX_CTRL]) |=> ((rdata & CTRL_ONES) == CTRL_ONES));

  a_r6_subp_cleared_bits: assert property (@(posedge clk) disable iff (rst)
    (wr && hit[IX_SUBP]) |=> ((subpanel & ~SUBP_KEEP) == '0));

  a_r7_stray_write: assert property (@(posedge clk) disable iff (rst)
    (wr && hit == '0) |=> ($stable(subpanel) && $stable(width_m1)
                           && $stable(height_m1) && $stable(mode)));

  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/pnl_csr.sv
module pnl_csr
  import pnl_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pal_evt,
  input  logic              sync_evt,
  output logic              irq,
  output logic              cfg_enable,
  output logic [1:0]        cfg_load_mode,
  output logic              cfg_tft,
  output logic              cfg_mono,
  output logic [DIM_W-1:0]  cfg_width_m1,
  output logic [DIM_W-1:0]  cfg_height_m1,
  output logic [31:0]       cfg_subpanel
);

  logic [NREG-1:0] hit;
  logic [1:0]      mask;
  logic            en;
  flag_vec_t       flags;

  pnl_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  pnl_csr_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (bus_wr && hit[IX_CTRL]),
    .wr_en    (bus_wdata[CB_EN]),
    .wr_mode  (bus_wdata[CB_MODE +: 2]),
    .mask     (mask),
    .pal_evt  (pal_evt),
    .sync_evt (sync_evt),
    .en       (en),
    .flags    (flags),
    .irq      (irq)
  );

  pnl_csr_bank #(.DIM_W(DIM_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .hit       (hit),
    .wdata     (bus_wdata),
    .en        (en),
    .flags     (flags),
    .rdata     (bus_rdata),
    .mode      (cfg_load_mode),
    .mask      (mask),
    .tft       (cfg_tft),
    .mono      (cfg_mono),
    .width_m1  (cfg_width_m1),
    .height_m1 (cfg_height_m1),
    .subpanel  (cfg_subpanel)
  );

  assign cfg_enable = en;

  a_r8_irq_drops: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit[IX_CTRL] && bus_wdata[4:3] == 2'b00 && !flags.sync
     && !sync_evt && !en) |=> !irq);

endmodule

// File: tb/sim_pnl_csr.sv
module sim_pnl_csr;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pal_evt = 1'b0, sync_evt = 1'b0;
  logic        irq, cfg_enable, cfg_tft, cfg_mono;
  logic [1:0]  cfg_load_mode;
  logic [9:0]  cfg_width_m1, cfg_height_m1;
  logic [31:0] cfg_subpanel;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv, held;

  always #(CLK_PERIOD/2) clk = ~clk;

  pnl_csr u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pal_evt(pal_evt), .sync_evt(sync_evt), .irq(irq),
    .cfg_enable(cfg_enable), .cfg_load_mode(cfg_load_mode),
    .cfg_tft(cfg_tft), .cfg_mono(cfg_mono),
    .cfg_width_m1(cfg_width_m1), .cfg_height_m1(cfg_height_m1),
    .cfg_subpanel(cfg_subpanel)
  );

  // {is_read, requirement, offset, data-or-expected}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b0, 4'd3, 8'h04, 32'h1234_5670},   // R3
    {1'b1, 4'd3, 8'h04, 32'h1234_567f},
    {1'b0, 4'd3, 8'h08, 32'h0abc_d1e0},
    {1'b1, 4'd3, 8'h08, 32'h0abc_d1e0},
    {1'b0, 4'd4, 8'h0c, 32'h0123_4567},   // R4
    {1'b1, 4'd4, 8'h0c, 32'hfd23_4567},
    {1'b0, 4'd6, 8'h14, 32'hffff_ffff},   // R6
    {1'b1, 4'd6, 8'h14, 32'ha1ff_ffff},
    {1'b0, 4'd6, 8'h14, 32'h5e00_1234},
    {1'b1, 4'd6, 8'h14, 32'h0000_1234},
    {1'b0, 4'd7, 8'h40, 32'hffff_ffff},   // R7
    {1'b1, 4'd7, 8'h40, 32'h0000_0000},
    {1'b1, 4'd7, 8'h04, 32'h1234_567f},
    {1'b0, 4'd2, 8'h00, 32'h0130_0386},   // R2
    {1'b1, 4'd2, 8'h00, 32'hffb0_0fb6},
    {1'b0, 4'd5, 8'h10, 32'hffff_ffff},   // R5
    {1'b1, 4'd5, 8'h10, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_ev(input logic [7:0] a, input logic [31:0] d,
                       input logic pe, input logic se);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; pal_evt = pe; sync_evt = se;
    @(negedge clk);
    bus_wr = 1'b0; pal_evt = 1'b0; sync_evt = 1'b0;
  endtask

  task automatic pulse(input logic pe, input logic se);
    @(negedge clk);
    pal_evt = pe; sync_evt = se;
    @(negedge clk);
    pal_evt = 1'b0; sync_evt = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 enable", 32'(cfg_enable), 0);
    chk("R1 width", 32'(cfg_width_m1), 0);
    rd_reg(8'h00, rv); chk("R1 ctrl", rv, 32'hfe00_0c34);
    rd_reg(8'h04, rv); chk("R1 tim0", rv, 32'h0000_000f);
    rd_reg(8'h08, rv); chk("R1 tim1", rv, 32'h0);
    rd_reg(8'h0c, rv); chk("R1 tim2", rv, 32'hfc00_0000);
    rd_reg(8'h10, rv); chk("R1 stat", rv, 32'h0);
    rd_reg(8'h14, rv); chk("R1 subp", rv, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][44]) begin
        rd_reg(VEC[i][39:32], rv);
        chk($sformatf("R%0d vector %0d", VEC[i][43:40], i), rv, VEC[i][31:0]);
      end else begin
        wr_ev(VEC[i][39:32], VEC[i][31:0], 1'b0, 1'b0);
      end
    end
    chk("R3 width out", 32'(cfg_width_m1), 32'h270);
    chk("R3 height out", 32'(cfg_height_m1), 32'h1e0);
    chk("R2 mode out", 32'(cfg_load_mode), 3);
    chk("R2 tft/mono out", {30'b0, cfg_tft, cfg_mono}, 32'h3);
    chk("R6 subpanel out", cfg_subpanel, 32'h0000_1234);

    // R10 enable from idle, mask both, mode 0; R11 palette event; R8 masked irq
    wr_ev(8'h00, 32'h0000_0019, 1'b0, 1'b0);
    chk("R2 enable out", 32'(cfg_enable), 1);
    rd_reg(8'h10, rv); chk("R10 stat after enable", rv, 32'h0);
    pulse(1'b1, 1'b0);
    rd_reg(8'h10, rv); chk("R11 pal set", rv, 32'h40);
    chk("R8 irq pal", 32'(irq), 1);
    // R9 disable, mode 0 -> frame-done set
    wr_ev(8'h00, 32'h0000_0018, 1'b0, 1'b0);
    rd_reg(8'h10, rv); chk("R9 disable frame", rv, 32'h41);
    wr_ev(8'h00, 32'h0000_0000, 1'b0, 1'b0);
    chk("R8 irq masked", 32'(irq), 0);
    rd_reg(8'h10, rv); chk("R5 flags held", rv, 32'h41);
    wr_ev(8'h00, 32'h0000_0001, 1'b0, 1'b0);
    rd_reg(8'h10, rv); chk("R10 idle clear", rv, 32'h0);

    // R11 sync event: unmasked irq, enable dropped, not idle
    pulse(1'b0, 1'b1);
    rd_reg(8'h10, rv); chk("R11 sync set", rv, 32'h04);
    chk("R11 enable dropped", 32'(cfg_enable), 0);
    chk("R8 irq sync unmasked", 32'(irq), 1);
    rd_reg(8'h00, rv); chk("R11 ctrl en low", rv, 32'hfe00_0c34);
    pulse(1'b1, 1'b0);
    wr_ev(8'h00, 32'h0000_0001, 1'b0, 1'b0);
    rd_reg(8'h10, rv); chk("R10 no clear when not idle", rv, 32'h44);
    // R9 disable with load mode 1: no frame-done, sync cleared
    wr_ev(8'h00, 32'h0010_0000, 1'b0, 1'b0);
    rd_reg(8'h10, rv); chk("R9 mode1 disable", rv, 32'h40);
    chk("R8 irq none", 32'(irq), 0);

    // R12 same-cycle collisions
    wr_ev(8'h00, 32'h0000_0001, 1'b0, 1'b0);
    rd_reg(8'h10, rv); chk("R10 idle clear again", rv, 32'h0);
    wr_ev(8'h00, 32'h0000_0000, 1'b0, 1'b1);
    rd_reg(8'h10, rv); chk("R12 disable+sync", rv, 32'h05);
    chk("R12 enable low", 32'(cfg_enable), 0);
    wr_ev(8'h00, 32'h0000_0001, 1'b1, 1'b0);
    rd_reg(8'h10, rv); chk("R12 enable+pal", rv, 32'h44);
    chk("R12 irq", 32'(irq), 1);

    // R13 read data holds without a read strobe
    rd_reg(8'h0c, held);
    wr_ev(8'h0c, 32'h0000_0000, 1'b0, 1'b0);
    @(negedge clk);
    chk("R13 rdata hold", bus_rdata, held);
    rd_reg(8'h0c, rv); chk("R13 new read", rv, 32'hfc00_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule